// File: doc/BRIEF.md
# LCL Filter Reference Trajectory Generator

This block turns one bus voltage sample and one reference voltage sample into the four per-sample references a single-phase bridge inverter with an LCL output filter should follow: output current, filter capacitor voltage, inductor current and bridge voltage. The output current comes from an admittance law in PID form on the error between bus and reference voltage. The other three references come from backward differences through the filter equations, working from the bus side towards the bridge. Together they make the inverter look like an ideal voltage source behind a virtual admittance.

Each accepted sample produces one output set after a fixed pipeline latency. The gains and the scaled filter coefficients (series inductance, capacitance and bridge inductance, each divided by the sample period) are static inputs. All are signed Q8 fixed point, so a value of 256 means 1.0. The caller sets the gains according to the sign of the desired susceptance, so only one of the integral and derivative gains is non-zero. A software-set bound limits the running error sum.

Top module: `lcl_traj_gen`

## Requirements
- R1: With e = vbus_i - vref_i, the current reference is io = sat16((kp·e + ki_h·S + kd_h·(e - e_prev)) >>> 8). Here S is the clamped error sum, e_prev is the error of the previous accepted sample, `>>>` is an arithmetic (floor) shift, and sat16 clamps to [-32768, 32767].
- R2: S holds the errors of earlier samples only. The current error is added after io is formed, so the first sample after reset sees S = 0.
- R3: After each sample, S becomes S + e clamped to [-int_lim_i, +int_lim_i]. It never wraps.
- R4: The capacitor voltage reference is vc = sat16(vbus - ((lcon_h·(io - io_prev)) >>> 8)).
- R5: The inductor current reference is il = sat16(((cap_h·(vc - vc_prev)) >>> 8) - io).
- R6: The bridge voltage reference is vh = sat16(((lbr_h·(il - il_prev)) >>> 8) + vc).
- R7: Every reference saturates at the 16-bit signed limits instead of wrapping.
- R8: Each cycle with valid_i high yields exactly one cycle of valid_o, four clock edges later. This holds for back-to-back samples too. All four outputs change only in that cycle and hold between samples.
- R9: Reset clears every history value (e_prev, S, io_prev, vc_prev, il_prev), the outputs and valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample strobe |
| vbus_i | input | 16 | Bus voltage sample, signed |
| vref_i | input | 16 | Reference voltage sample, signed |
| kp_i | input | 16 | Proportional gain, signed Q8 |
| ki_h_i | input | 16 | Integral gain times sample period, signed Q8 |
| kd_h_i | input | 16 | Derivative gain over sample period, signed Q8 |
| lcon_h_i | input | 16 | Series inductance over sample period, signed Q8 |
| cap_h_i | input | 16 | Capacitance over sample period, signed Q8 |
| lbr_h_i | input | 16 | Bridge inductance over sample period, signed Q8 |
| int_lim_i | input | 23 | Bound on the error sum, unsigned |
| valid_o | output | 1 | Output set strobe |
| io_o | output | 16 | Output current reference |
| vc_o | output | 16 | Capacitor voltage reference |
| il_o | output | 16 | Inductor current reference |
| vh_o | output | 16 | Bridge voltage reference |

## Verification
The hardest state to reach from the ports is an error sum pinned at its bound, then driven off it in the opposite direction. Random voltages rarely hold the sum against a small limit long enough to show that. Directed runs therefore use only the integral gain at unity, a small bound and a constant error of one sign, then flip the sign. Because only the integral path is active, io_o shows the clamped sum directly. Random coefficient sets sent as back-to-back bursts and gapped samples check that each stage's history advances exactly once per sample.

// File: rtl/lcl_traj_pkg.sv
package lcl_traj_pkg;
  localparam int DATA_W = 16;
  localparam int COEF_W = 16;
  localparam int ACC_W  = 24;
  localparam int FRAC   = 8;

  function automatic logic signed [63:0] sat_to(input logic signed [63:0] v, input int w);
    logic signed [63:0] hi;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    if (v > hi) return hi;
    if (v < -hi - 64'sd1) return -hi - 64'sd1;
    return v;
  endfunction
endpackage

// File: rtl/lcl_io_law.sv
module lcl_io_law
  import lcl_traj_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = COEF_W,
  parameter int AW = ACC_W,
  parameter int FB = FRAC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] vbus_i,
  input  logic signed [DW-1:0] vref_i,
  input  logic signed [CW-1:0] kp_i,
  input  logic signed [CW-1:0] ki_h_i,
  input  logic signed [CW-1:0] kd_h_i,
  input  logic        [AW-2:0] int_lim_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] io_o,
  output logic signed [DW-1:0] vbus_o
);
  localparam int SW = AW + CW + 2;

  logic signed [DW:0]   err, err_q;
  logic signed [DW+1:0] derr;
  logic signed [AW-1:0] acc_q;
  logic signed [AW:0]   acc_sum, lim_s, acc_nx;
  logic signed [SW-1:0] p_kp, p_ki, p_kd, p_sum, p_shr;
  logic signed [DW-1:0] io_n;

  always_comb begin
    err   = (DW+1)'(vbus_i) - (DW+1)'(vref_i);
    derr  = (DW+2)'(err) - (DW+2)'(err_q);
    p_kp  = SW'(kp_i) * SW'(err);
    p_ki  = SW'(ki_h_i) * SW'(acc_q);   // sum of earlier samples only
    p_kd  = SW'(kd_h_i) * SW'(derr);
    p_sum = p_kp + p_ki + p_kd;
    p_shr = p_sum >>> FB;
    io_n  = DW'(sat_to(64'(p_shr), DW));
    acc_sum = (AW+1)'(acc_q) + (AW+1)'(err);
    lim_s   = $signed({2'b00, int_lim_i});
    if (acc_sum > lim_s)       acc_nx = lim_s;
    else if (acc_sum < -lim_s) acc_nx = -lim_s;
    else                       acc_nx = acc_sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      acc_q   <= '0;
      io_o    <= '0;
      vbus_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        err_q  <= err;
        acc_q  <= AW'(acc_nx);
        io_o   <= io_n;
        vbus_o <= vbus_i;
      end
    end
  end

  assert_acc_clamp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (acc_q <= $signed({2'b00, $past(int_lim_i)}) &&
                 acc_q >= -$signed({2'b00, $past(int_lim_i)})));

  assert_hist_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(acc_q) && $stable(err_q) && $stable(io_o)));
endmodule

// File: rtl/lcl_diff_stage.sv
module lcl_diff_stage
  import lcl_traj_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int CW  = COEF_W,
  parameter int FB  = FRAC,
  parameter bit NEG = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW:0]   add_i,
  input  logic signed [CW-1:0] coef_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] y_o
);
  localparam int PW = DW + CW + 3;

  logic signed [DW-1:0] x_q;
  logic signed [DW:0]   dx;
  logic signed [PW-1:0] prod, term, sum;
  logic signed [DW-1:0] y_n;

  always_comb begin
    dx   = (DW+1)'(x_i) - (DW+1)'(x_q);
    prod = PW'(coef_i) * PW'(dx);
    term = prod >>> FB;
  end

  generate
    if (NEG) begin : g_sub
      assign sum = PW'(add_i) - term;
    end else begin : g_add
      assign sum = PW'(add_i) + term;
    end
  endgenerate

  assign y_n = DW'(sat_to(64'(sum), DW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      y_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        x_q <= x_i;
        y_o <= y_n;
      end
    end
  end

  assert_stage_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(y_o) && $stable(x_q)));
endmodule

// File: rtl/lcl_traj_gen.sv
module lcl_traj_gen
  import lcl_traj_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = COEF_W,
  parameter int AW = ACC_W,
  parameter int FB = FRAC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] vbus_i,
  input  logic signed [DW-1:0] vref_i,
  input  logic signed [CW-1:0] kp_i,
  input  logic signed [CW-1:0] ki_h_i,
  input  logic signed [CW-1:0] kd_h_i,
  input  logic signed [CW-1:0] lcon_h_i,
  input  logic signed [CW-1:0] cap_h_i,
  input  logic signed [CW-1:0] lbr_h_i,
  input  logic        [AW-2:0] int_lim_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] io_o,
  output logic signed [DW-1:0] vc_o,
  output logic signed [DW-1:0] il_o,
  output logic signed [DW-1:0] vh_o
);
  logic                 va, vb, vcv;
  logic signed [DW-1:0] io_a, vbus_a, vc_b, il_c;
  logic signed [DW-1:0] io_b, io_c, vc_c, io_d, vc_d, il_d;
  logic signed [DW:0]   neg_io_b, vc_c_x, vbus_a_x;

  lcl_io_law #(.DW(DW), .CW(CW), .AW(AW), .FB(FB)) u_io (
    .clk_i, .rst_ni, .valid_i, .vbus_i, .vref_i, .kp_i, .ki_h_i, .kd_h_i, .int_lim_i,
    .valid_o(va), .io_o(io_a), .vbus_o(vbus_a)
  );

  assign vbus_a_x = (DW+1)'(vbus_a);
  // capacitor voltage: bus voltage minus series-inductor drop
  lcl_diff_stage #(.DW(DW), .CW(CW), .FB(FB), .NEG(1'b1)) u_vc (
    .clk_i, .rst_ni, .valid_i(va), .x_i(io_a), .add_i(vbus_a_x), .coef_i(lcon_h_i),
    .valid_o(vb), .y_o(vc_b)
  );

  assign neg_io_b = -(DW+1)'(io_b);
  lcl_diff_stage #(.DW(DW), .CW(CW), .FB(FB), .NEG(1'b0)) u_il (
    .clk_i, .rst_ni, .valid_i(vb), .x_i(vc_b), .add_i(neg_io_b), .coef_i(cap_h_i),
    .valid_o(vcv), .y_o(il_c)
  );

  assign vc_c_x = (DW+1)'(vc_c);
  lcl_diff_stage #(.DW(DW), .CW(CW), .FB(FB), .NEG(1'b0)) u_vh (
    .clk_i, .rst_ni, .valid_i(vcv), .x_i(il_c), .add_i(vc_c_x), .coef_i(lbr_h_i),
    .valid_o(valid_o), .y_o(vh_o)
  );

  // align the earlier references with the bridge-voltage stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_b <= '0;
      io_c <= '0;
      vc_c <= '0;
      io_d <= '0;
      vc_d <= '0;
      il_d <= '0;
    end else begin
      if (va) io_b <= io_a;
      if (vb) begin
        io_c <= io_b;
        vc_c <= vc_b;
      end
      if (vcv) begin
        io_d <= io_c;
        vc_d <= vc_c;
        il_d <= il_c;
      end
    end
  end

  assign io_o = io_d;
  assign vc_o = vc_d;
  assign il_o = il_d;

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##4 valid_o);

  assert_no_spurious_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 4));
endmodule

// File: tb/lcl_traj_gen_tb_top.sv
module lcl_traj_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QN = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic signed [15:0] vbus_i = '0, vref_i = '0;
  logic signed [15:0] kp = '0, ki = '0, kd = '0, lc = '0, ch = '0, lh = '0;
  logic [22:0] lim = '0;
  logic valid_o;
  logic signed [15:0] io_o, vc_o, il_o, vh_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcl_traj_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .vbus_i(vbus_i), .vref_i(vref_i),
    .kp_i(kp), .ki_h_i(ki), .kd_h_i(kd), .lcon_h_i(lc), .cap_h_i(ch), .lbr_h_i(lh),
    .int_lim_i(lim), .valid_o(valid_o), .io_o(io_o), .vc_o(vc_o), .il_o(il_o), .vh_o(vh_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint m_ep, m_acc, m_iop, m_vcp, m_ilp;
  longint q_io[QN], q_vc[QN], q_il[QN], q_vh[QN];
  int q_cyc[QN];
  int wr = 0, rd = 0;
  bit seen = 0;
  logic signed [15:0] last_io, last_vc, last_il, last_vh;

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_ep = 0; m_acc = 0; m_iop = 0; m_vcp = 0; m_ilp = 0;
  endtask

  task automatic send(input int vb, input int vr);
    longint e, io, vc, il, vh, s;
    e  = longint'(vb) - longint'(vr);
    io = sat16((longint'(kp) * e + longint'(ki) * m_acc + longint'(kd) * (e - m_ep)) >>> 8);
    s  = m_acc + e;
    if (s > longint'(lim)) s = longint'(lim);
    if (s < -longint'(lim)) s = -longint'(lim);
    m_acc = s; m_ep = e;
    vc = sat16(longint'(vb) - ((longint'(lc) * (io - m_iop)) >>> 8)); m_iop = io;
    il = sat16(((longint'(ch) * (vc - m_vcp)) >>> 8) - io); m_vcp = vc;
    vh = sat16(((longint'(lh) * (il - m_ilp)) >>> 8) + vc); m_ilp = il;
    q_io[wr % QN] = io; q_vc[wr % QN] = vc; q_il[wr % QN] = il; q_vh[wr % QN] = vh;
    q_cyc[wr % QN] = cyc;
    wr++;
    valid_i = 1'b1;
    vbus_i = 16'(vb);
    vref_i = 16'(vr);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    while (rd != wr) @(negedge clk);
  endtask

  task automatic do_reset();
    drain();
    rst_n = 1'b0;
    model_clear();
    seen = 0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  // monitor: every output set against the model; R8 latency and hold
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        if (rd == wr) chk("R8 spurious valid_o", 1, 0);
        else begin
          chk("R1 io", io_o, q_io[rd % QN]);
          chk("R4 vc", vc_o, q_vc[rd % QN]);
          chk("R5 il", il_o, q_il[rd % QN]);
          chk("R6 vh", vh_o, q_vh[rd % QN]);
          chk("R8 latency", cyc, q_cyc[rd % QN] + 4);
          rd++;
        end
        seen = 1;
        last_io = io_o; last_vc = vc_o; last_il = il_o; last_vh = vh_o;
      end else if (seen) begin
        if (io_o !== last_io || vc_o !== last_vc || il_o !== last_il || vh_o !== last_vh)
          chk("R8 hold", 1, 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_clear();
    void'($urandom(32'd4711));
    idle(2);
    // R9: outputs cleared under reset
    chk("R9 reset valid_o", valid_o, 0);
    chk("R9 reset io", io_o, 0);
    chk("R9 reset vh", vh_o, 0);
    rst_n = 1'b1;
    idle(1);

    // R2: first sample sees an empty sum
    kp = 0; ki = 256; kd = 0; lc = 64; ch = 32; lh = 16; lim = 23'd1000;
    send(100, 0); drain();
    chk("R2 first sample io", io_o, 0);
    send(100, 0); drain();
    chk("R2 second sample io", io_o, 100);

    // R3: sum pinned at +lim, then driven to -lim
    do_reset();
    lim = 23'd50;
    send(100, 0); send(100, 0); send(100, 0); drain();
    chk("R3 clamp high io", io_o, 50);
    send(-100, 0); send(-100, 0); drain();
    chk("R3 clamp low io", io_o, -50);

    // R7: output clamp at both rails
    kp = 16'sd32767; ki = 0; kd = 0;
    send(1000, 0); drain();
    chk("R7 io high rail", io_o, 32767);
    send(-1000, 0); drain();
    chk("R7 io low rail", io_o, -32768);
    kp = 256; lc = 16'sd32767; lh = 16'sd32767; ch = 16'sd32767;
    send(30000, -2000); send(-30000, 2000); send(5, 0); drain();

    // R9: mid-run reset clears history
    do_reset();
    kp = 0; ki = 0; kd = 256; lc = 0; ch = 0; lh = 0;
    send(300, 100); drain();
    chk("R9 history cleared io", io_o, 200);
    chk("R9 history cleared vc", vc_o, 300);

    // random coefficient sets, bursts and gaps (R1 R4 R5 R6 R8)
    for (int s = 0; s < 6; s++) begin
      drain();
      kp = 16'($urandom_range(0, 600));
      if (s % 2 == 0) begin ki = 16'($urandom_range(0, 255)); kd = 0; end
      else begin ki = 0; kd = 16'($urandom_range(0, 400)); end
      lc = 16'($urandom_range(0, 1500));
      ch = 16'($urandom_range(0, 1500));
      lh = 16'($urandom_range(0, 1500));
      lim = 23'($urandom_range(10, 200000));
      for (int i = 0; i < 60; i++) begin
        send(int'($urandom_range(0, 24000)) - 12000, int'($urandom_range(0, 24000)) - 12000);
        if ($urandom_range(0, 2) == 0) idle(int'($urandom_range(1, 5)));
      end
    end
    drain();
    idle(3);
    chk("R8 all samples returned", rd, wr);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule